// File: doc/BRIEF.md
# VGA 640x400 Sync Timing Generator

This block produces the horizontal and vertical timing for a 640x400, 70 Hz monochrome display mode. A single clock-enable input marks each pixel period; with a 100 MHz system clock the enable is expected high one cycle in four, which gives a 25 MHz pixel rate. On each enable the block advances a pixel position within the line. When that position wraps, the block advances a line position within the frame.

From the two positions it decodes an active-low horizontal sync, an active-high vertical sync, and a line-visible and a pixel-visible qualifier. It also raises two one-cycle strobes, one when a line starts and one when a frame starts. A downstream pixel fetcher uses these strobes to step its address. The block holds no pixel data and reads no memory.

The frame is 450 lines long. The vertical sync pulse comes early, on lines 2 and 3. The 400 visible lines are lines 38 to 437. Every edge is placed by a fixed compare value, and each compare value is a parameter.

Top module: `vga_sync_gen`

## Requirements
- R1: The pixel position `pixX` advances by one only in a cycle where `pixEn` is high. In every other cycle it holds its value.
- R2: Each line lasts LINE_LEN enables (default 800). `pixX` goes from LINE_LEN-1 back to 0.
- R3: `hSyncN` is low while HS_START <= `pixX` < HS_END (default 16 to 47, which is 32 pixels). Otherwise it is high.
- R4: `lineY` advances by one on each enable that wraps `pixX`. It goes from FRAME_LINES-1 (default 449) back to 0.
- R5: `vSync` is high while VS_START <= `lineY` < VS_END (default lines 2 and 3). Otherwise it is low.
- R6: `lineVisible` is high while V_VIS_START <= `lineY` < V_VIS_END (default 38 to 437, which is 400 lines).
- R7: `pixelVisible` is high when `lineVisible` is high and H_VIS_START <= `pixX` < H_VIS_START+H_VIS_LEN (default 0 to 639).
- R8: `lineStart` is high in exactly those cycles where `pixEn` is high and `pixX` equals LINE_LEN-1. That is the enable that starts the next line.
- R9: `frameStart` is high in exactly those cycles where `lineStart` is high and `lineY` equals FRAME_LINES-1.
- R10: A synchronous active-high `rst` sets both positions to 0, whatever `pixEn` is doing. After reset `hSyncN` is high and `vSync` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pixEn | input | 1 | Pixel-period enable |
| hSyncN | output | 1 | Horizontal sync, active low |
| vSync | output | 1 | Vertical sync, active high |
| lineVisible | output | 1 | Current line is in the visible band |
| pixelVisible | output | 1 | Current pixel is in the visible window |
| lineStart | output | 1 | One-cycle strobe on the enable that wraps the line |
| frameStart | output | 1 | One-cycle strobe on the enable that wraps the frame |
| pixX | output | $clog2(LINE_LEN+1) | Pixel position in the line |
| lineY | output | $clog2(FRAME_LINES+1) | Line position in the frame |

## Verification
The bench drives an irregular enable pattern, so a counter that advances on the clock instead of on `pixEn` drifts away from the reference at once. It probes the first and last position of every window: sync fall and rise, the visible start and end column, and the first and last visible line. These probes catch an off-by-one compare, which would widen or narrow a pulse by one pixel or one line. The bench runs through the last pixel of the last line. A wrap placed one count early or late then shows up as a missing or misplaced `frameStart`. Finally, reset is applied in the middle of the sync band while enables keep arriving. A reset that only took effect on an enable, or that left `vSync` set, is caught there.

// File: rtl/vga_sync_pkg.sv
package vga_sync_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic pixAdv;     // step the pixel position
    logic lineWrap;   // pixel position wraps; step the line
    logic frameWrap;  // line position wraps as well
  } syncStb_t;

endpackage

// File: rtl/vga_sync_ctrl.sv
module vga_sync_ctrl
  import vga_sync_pkg::*;
#(
  parameter int LINE_LEN    = 800,
  parameter int FRAME_LINES = 450,
  localparam int XW = $clog2(LINE_LEN + 1),
  localparam int YW = $clog2(FRAME_LINES + 1)
) (
  input  logic          pixEn,
  input  logic [XW-1:0] pixX,
  input  logic [YW-1:0] lineY,
  output syncStb_t      stb
);

  localparam logic [XW-1:0] X_LAST = XW'(LINE_LEN - 1);
  localparam logic [YW-1:0] Y_LAST = YW'(FRAME_LINES - 1);

  always_comb begin
    stb.pixAdv    = pixEn;
    stb.lineWrap  = pixEn && (pixX == X_LAST);
    stb.frameWrap = stb.lineWrap && (lineY == Y_LAST);
  end

endmodule

// File: rtl/vga_sync_dp.sv
module vga_sync_dp
  import vga_sync_pkg::*;
#(
  parameter int LINE_LEN    = 800,
  parameter int FRAME_LINES = 450,
  parameter int HS_START    = 16,
  parameter int HS_END      = 48,
  parameter int H_VIS_START = 0,
  parameter int H_VIS_LEN   = 640,
  parameter int VS_START    = 2,
  parameter int VS_END      = 4,
  parameter int V_VIS_START = 38,
  parameter int V_VIS_END   = 438,
  localparam int XW = $clog2(LINE_LEN + 1),
  localparam int YW = $clog2(FRAME_LINES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  syncStb_t      stb,
  output logic [XW-1:0] pixX,
  output logic [YW-1:0] lineY,
  output logic          hSyncN,
  output logic          vSync,
  output logic          lineVisible,
  output logic          pixelVisible
);

  localparam logic [XW-1:0] HS_ON  = XW'(HS_START);
  localparam logic [XW-1:0] HS_OFF = XW'(HS_END);
  localparam logic [XW-1:0] HV_ON  = XW'(H_VIS_START);
  localparam logic [XW-1:0] HV_OFF = XW'(H_VIS_START + H_VIS_LEN);
  localparam logic [YW-1:0] VS_ON  = YW'(VS_START);
  localparam logic [YW-1:0] VS_OFF = YW'(VS_END);
  localparam logic [YW-1:0] VV_ON  = YW'(V_VIS_START);
  localparam logic [YW-1:0] VV_OFF = YW'(V_VIS_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      pixX  <= '0;
      lineY <= '0;
    end else if (stb.pixAdv) begin
      if (stb.lineWrap) pixX <= '0;
      else              pixX <= pixX + 1'b1;
      if (stb.frameWrap)     lineY <= '0;
      else if (stb.lineWrap) lineY <= lineY + 1'b1;
    end
  end

  logic hInWin;

  // A window starting at column 0 needs no lower compare
  generate
    if (H_VIS_START == 0) begin : g_hwinZero
      assign hInWin = (pixX < HV_OFF);
    end else begin : g_hwinOfs
      assign hInWin = (pixX >= HV_ON) && (pixX < HV_OFF);
    end
  endgenerate

  always_comb begin
    hSyncN       = !((pixX >= HS_ON) && (pixX < HS_OFF));
    vSync        = (lineY >= VS_ON) && (lineY < VS_OFF);
    lineVisible  = (lineY >= VV_ON) && (lineY < VV_OFF);
    pixelVisible = lineVisible && hInWin;
  end

endmodule

// File: rtl/vga_sync_gen.sv
module vga_sync_gen
  import vga_sync_pkg::*;
#(
  parameter int LINE_LEN    = 800,
  parameter int FRAME_LINES = 450,
  parameter int HS_START    = 16,
  parameter int HS_END      = 48,
  parameter int H_VIS_START = 0,
  parameter int H_VIS_LEN   = 640,
  parameter int VS_START    = 2,
  parameter int VS_END      = 4,
  parameter int V_VIS_START = 38,
  parameter int V_VIS_END   = 438,
  localparam int XW = $clog2(LINE_LEN + 1),
  localparam int YW = $clog2(FRAME_LINES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pixEn,
  output logic          hSyncN,
  output logic          vSync,
  output logic          lineVisible,
  output logic          pixelVisible,
  output logic          lineStart,
  output logic          frameStart,
  output logic [XW-1:0] pixX,
  output logic [YW-1:0] lineY
);

  syncStb_t stb;

  vga_sync_ctrl #(
    .LINE_LEN(LINE_LEN), .FRAME_LINES(FRAME_LINES)
  ) u_ctrl (
    .pixEn(pixEn), .pixX(pixX), .lineY(lineY), .stb(stb)
  );

  vga_sync_dp #(
    .LINE_LEN(LINE_LEN), .FRAME_LINES(FRAME_LINES),
    .HS_START(HS_START), .HS_END(HS_END),
    .H_VIS_START(H_VIS_START), .H_VIS_LEN(H_VIS_LEN),
    .VS_START(VS_START), .VS_END(VS_END),
    .V_VIS_START(V_VIS_START), .V_VIS_END(V_VIS_END)
  ) u_dp (
    .clk(clk), .rst(rst), .stb(stb),
    .pixX(pixX), .lineY(lineY),
    .hSyncN(hSyncN), .vSync(vSync),
    .lineVisible(lineVisible), .pixelVisible(pixelVisible)
  );

  assign lineStart  = stb.lineWrap;
  assign frameStart = stb.frameWrap;

endmodule

// File: rtl/vga_sync_chk.sv
module vga_sync_chk #(
  parameter int LINE_LEN    = 800,
  parameter int FRAME_LINES = 450,
  parameter int HS_START    = 16,
  parameter int VS_START    = 2,
  localparam int XW = $clog2(LINE_LEN + 1),
  localparam int YW = $clog2(FRAME_LINES + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          pixEn,
  input logic          hSyncN,
  input logic          vSync,
  input logic          lineStart,
  input logic          frameStart,
  input logic [XW-1:0] pixX,
  input logic [YW-1:0] lineY
);

  a_r1_hold_without_enable: assert property (@(posedge clk) disable iff (rst)
    !pixEn |=> $stable(pixX) && $stable(lineY));

  a_r2_pixel_wraps: assert property (@(posedge clk) disable iff (rst)
    (pixEn && pixX == XW'(LINE_LEN - 1)) |=> pixX == '0);

  a_r3_hsync_falls_at_start: assert property (@(posedge clk) disable iff (rst)
    $fell(hSyncN) |-> pixX == XW'(HS_START));

  a_r4_frame_wraps: assert property (@(posedge clk) disable iff (rst)
    frameStart |=> lineY == '0 && pixX == '0);

  a_r5_vsync_rises_at_start: assert property (@(posedge clk) disable iff (rst)
    $rose(vSync) |-> lineY == YW'(VS_START));

  a_r9_frame_implies_line: assert property (@(posedge clk) disable iff (rst)
    frameStart |-> lineStart);

  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> pixX == '0 && lineY == '0);

endmodule

bind vga_sync_gen vga_sync_chk #(
  .LINE_LEN(LINE_LEN), .FRAME_LINES(FRAME_LINES),
  .HS_START(HS_START), .VS_START(VS_START)
) u_chk (
  .clk(clk), .rst(rst), .pixEn(pixEn), .hSyncN(hSyncN), .vSync(vSync),
  .lineStart(lineStart), .frameStart(frameStart), .pixX(pixX), .lineY(lineY)
);

// File: tb/vga_sync_gen_test.sv
module vga_sync_gen_test;

  // Scaled timing so that whole frames fit in the run
  localparam int LL = 40, FL = 20, HSS = 4, HSE = 8, HVS = 3, HVL = 30;
  localparam int VSS = 2, VSE = 4, VVS = 6, VVE = 16;
  localparam int XW = $clog2(LL + 1), YW = $clog2(FL + 1);

  logic clk = 1'b0, rst = 1'b1, pixEn = 1'b0;
  logic hSyncN, vSync, lineVisible, pixelVisible, lineStart, frameStart;
  logic [XW-1:0] pixX;
  logic [YW-1:0] lineY;

  int total = 0, bad = 0, refX = 0, refY = 0, frames = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vga_sync_gen #(
    .LINE_LEN(LL), .FRAME_LINES(FL), .HS_START(HSS), .HS_END(HSE),
    .H_VIS_START(HVS), .H_VIS_LEN(HVL), .VS_START(VSS), .VS_END(VSE),
    .V_VIS_START(VVS), .V_VIS_END(VVE)
  ) uut (
    .clk(clk), .rst(rst), .pixEn(pixEn), .hSyncN(hSyncN), .vSync(vSync),
    .lineVisible(lineVisible), .pixelVisible(pixelVisible),
    .lineStart(lineStart), .frameStart(frameStart), .pixX(pixX), .lineY(lineY)
  );

  // probe: line, pixel, expected hSyncN, vSync, lineVisible, pixelVisible
  typedef struct packed { logic [7:0] y; logic [7:0] x; logic hs, vs, lv, pv; } probe_t;
  localparam int NP = 16;
  localparam probe_t PROBES [NP] = '{
    '{8'd0,  8'd0,  1'b1, 1'b0, 1'b0, 1'b0},
    '{8'd0,  8'd3,  1'b1, 1'b0, 1'b0, 1'b0},
    '{8'd0,  8'd4,  1'b0, 1'b0, 1'b0, 1'b0},
    '{8'd0,  8'd7,  1'b0, 1'b0, 1'b0, 1'b0},
    '{8'd0,  8'd8,  1'b1, 1'b0, 1'b0, 1'b0},
    '{8'd1,  8'd39, 1'b1, 1'b0, 1'b0, 1'b0},
    '{8'd2,  8'd0,  1'b1, 1'b1, 1'b0, 1'b0},
    '{8'd3,  8'd39, 1'b1, 1'b1, 1'b0, 1'b0},
    '{8'd4,  8'd0,  1'b1, 1'b0, 1'b0, 1'b0},
    '{8'd6,  8'd2,  1'b1, 1'b0, 1'b1, 1'b0},
    '{8'd6,  8'd3,  1'b1, 1'b0, 1'b1, 1'b1},
    '{8'd6,  8'd32, 1'b1, 1'b0, 1'b1, 1'b1},
    '{8'd6,  8'd33, 1'b1, 1'b0, 1'b1, 1'b0},
    '{8'd15, 8'd10, 1'b1, 1'b0, 1'b1, 1'b1},
    '{8'd16, 8'd10, 1'b1, 1'b0, 1'b0, 1'b0},
    '{8'd19, 8'd39, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One clock with the given enable; outputs compared against the reference
  task automatic step(input bit en);
    bit eLs, eFs;
    @(negedge clk);
    pixEn = en;
    #1;
    eLs = en && refX == LL - 1;
    eFs = eLs && refY == FL - 1;
    chk(int'(pixX) == refX, "R1 R2 pixX", int'(pixX), refX);
    chk(int'(lineY) == refY, "R4 lineY", int'(lineY), refY);
    chk(hSyncN == !(refX >= HSS && refX < HSE), "R3 hSyncN", hSyncN, !(refX >= HSS && refX < HSE));
    chk(vSync == (refY >= VSS && refY < VSE), "R5 vSync", vSync, refY >= VSS && refY < VSE);
    chk(lineVisible == (refY >= VVS && refY < VVE), "R6 lineVisible", lineVisible, refY >= VVS && refY < VVE);
    chk(pixelVisible == ((refY >= VVS && refY < VVE) && refX >= HVS && refX < HVS + HVL),
        "R7 pixelVisible", pixelVisible,
        (refY >= VVS && refY < VVE) && refX >= HVS && refX < HVS + HVL);
    chk(lineStart == eLs, "R8 lineStart", lineStart, eLs);
    chk(frameStart == eFs, "R9 frameStart", frameStart, eFs);
    @(posedge clk);
    if (en) begin
      if (eFs) frames++;
      if (refX == LL - 1) begin
        refX = 0;
        refY = (refY == FL - 1) ? 0 : refY + 1;
      end else refX++;
    end
  endtask

  initial begin
    #500000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cyc = 0;
    // R10: reset holds counters while enables arrive
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); pixEn = 1'b1;
    end
    @(negedge clk); pixEn = 1'b0; #1;
    chk(pixX == '0 && lineY == '0, "R10 reset counters", int'(pixX), 0);
    chk(hSyncN == 1'b1, "R10 reset hSyncN", hSyncN, 1);
    chk(vSync == 1'b0, "R10 reset vSync", vSync, 0);
    rst = 1'b0;

    // Table walk with an irregular enable pattern
    for (int p = 0; p < NP; p++) begin
      while (!(refY == int'(PROBES[p].y) && refX == int'(PROBES[p].x))) begin
        step(cyc % 3 != 1);
        cyc++;
      end
      @(negedge clk); pixEn = 1'b0; #1;
      chk(hSyncN == PROBES[p].hs, "R3 probe hSyncN", hSyncN, PROBES[p].hs);
      chk(vSync == PROBES[p].vs, "R5 probe vSync", vSync, PROBES[p].vs);
      chk(lineVisible == PROBES[p].lv, "R6 probe lineVisible", lineVisible, PROBES[p].lv);
      chk(pixelVisible == PROBES[p].pv, "R7 probe pixelVisible", pixelVisible, PROBES[p].pv);
    end

    // R4 R9: cross the frame wrap and run a second frame with steady enables
    while (frames < 2) step(1'b1);
    chk(frames == 2, "R9 frame count", frames, 2);

    // R1: a long gap without enables leaves the position untouched
    for (int i = 0; i < 7; i++) step(1'b0);
    chk(int'(pixX) == refX, "R1 idle hold", int'(pixX), refX);

    // R10: reset inside the vertical sync band while enables continue
    while (refY != VSS + 1) step(1'b1);
    @(negedge clk); rst = 1'b1; pixEn = 1'b1;
    @(negedge clk); pixEn = 1'b1;
    #1;
    chk(pixX == '0 && lineY == '0, "R10 midframe counters", int'(lineY), 0);
    chk(vSync == 1'b0, "R10 midframe vSync", vSync, 0);
    chk(hSyncN == 1'b1, "R10 midframe hSyncN", hSyncN, 1);
    @(negedge clk); rst = 1'b0; pixEn = 1'b0;
    refX = 0; refY = 0;
    for (int i = 0; i < 20; i++) step(1'b1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule